// File: doc/BRIEF.md
# Dual-Mode Host Bus Decoder

This block sits between an asynchronous 16-bit microprocessor bus and the register space of eight identical channel engines, plus one block of global control registers. Address and data are not multiplexed on this bus. The bus can use one of two strobe styles, chosen by a static mode pin:

- **Mode 0:** a single data strobe together with a read/write direction line.
- **Mode 1:** separate active-low read and write strobes.

The chip select, the strobes and the direction line are brought into the system clock domain through a synchronizer. An access is then detected from the synchronized signals.

The 12-bit address is decoded three ways. An address can select one channel, all channels at once (write only), or the global register region. The block produces:

- one-cycle write-enable and read-latch pulses toward the channels and the global block;
- a shared register offset and write-data bus;
- a registered read-data word with its output enable, for the bidirectional pad;
- an active-low interrupt, which is the OR of the channel interrupt requests.

The channel register files are outside the block. They return read data combinationally from the shared offset.

Top module: `host_bus_decoder`

## Requirements
- R1: With address bit 11 low, bits 10..8 select channel 0..7 and bits 7..0 give the register offset. Reads and writes reach only that channel.
- R2: With bit 11 high and bits 10..8 equal to 000, a write pulses the write enables of all eight channels together, with the same offset and data.
- R3: With bit 11 high, bit 9 low and bit 8 high, the access goes to the global registers, whatever the value of bit 10. No channel enable pulses.
- R4: A read from the broadcast address or from any other undecoded combination (bit 11 high and bits 10..8 in 010, 011, 100, 110 or 111) returns 0x0000 and produces no pulse. A write to an undecoded combination changes no register.
- R5: While chip select (active low) is high, strobe activity causes no pulse and the output enable stays low.
- R6: In mode 0, a low data strobe marks the access, and direction 1 means read. Write data is sampled when the access begins, so later changes during the strobe are ignored.
- R7: In mode 1, the active-low read and write strobes mark the access. Write data is sampled when the write strobe is released, so the value present at release is stored.
- R8: Every decoded access produces exactly one single-cycle write-enable pulse (one event for a broadcast) or exactly one read-latch pulse.
- R9: The output enable is high during a read only while chip select and the read strobe are active. It is low by the third clock edge after the strobe is released.
- R10: The interrupt output goes low one clock after any channel interrupt request is high, and returns high one clock after all requests are clear.
- R11: Under reset, the output enable, all pulses and the read data are zero, and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobe style: 0 data strobe with direction, 1 separate strobes |
| cs_ni | input | 1 | Chip select, active low |
| ds_ni | input | 1 | Data strobe, active low (mode 0) |
| rw_i | input | 1 | Direction, 1 read / 0 write (mode 0) |
| rd_ni | input | 1 | Read strobe, active low (mode 1) |
| wr_ni | input | 1 | Write strobe, active low (mode 1) |
| addr_i | input | 12 | Host address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data toward the pad |
| rdata_oe_o | output | 1 | Pad output enable |
| ch_we_o | output | 8 | Per-channel write-enable pulses |
| ch_re_o | output | 8 | Per-channel read-latch pulses |
| reg_addr_o | output | 8 | Register offset shared by channels and globals |
| reg_wdata_o | output | 16 | Write data shared by channels and globals |
| ch_rdata_i | input | 128 | Channel read words, channel n at bits 16n+15..16n |
| glb_we_o | output | 1 | Global register write pulse |
| glb_re_o | output | 1 | Global register read pulse |
| glb_rdata_i | input | 16 | Global register read word |
| ch_irq_i | input | 8 | Channel interrupt requests, active high |
| irq_no | output | 1 | Combined interrupt, active low |

## Verification
The decode is swept over every channel at the lowest, a middle and the highest register offset. Each channel value is written in one strobe mode and read back in the other, with a distinct word per channel and offset, so that crossed channel bits or offset bits show up as wrong data. The upper address region is swept over all eight values of bits 10..8 for both reads and writes. This separates broadcast, global (with bit 10 at both values), and undecoded addresses by their pulse counts and returned data. In both modes, the write data is changed partway through the strobe, which tells the start-of-access sampling of mode 0 apart from the release sampling of mode 1. A walking single interrupt bit confirms that every request line reaches the combined output.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_CHAN  = 2'd1,
    TGT_BCAST = 2'd2,
    TGT_GLOB  = 2'd3
  } tgt_e;
endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= RST_VAL;
        else         stage_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbd_strobe_ctrl.sv
module hbd_strobe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic cs_ns_i,
  input  logic ds_ns_i,
  input  logic rw_s_i,
  input  logic rd_ns_i,
  input  logic wr_ns_i,
  output logic start_o,
  output logic wr_cap_o,
  output logic wr_go_o,
  output logic rd_go_o,
  output logic oe_o
);
  logic active, rd_dir, stop;
  logic active_q, wr_pend_q, wr_go_q, rd_go_q, oe_q;

  assign active  = !cs_ns_i && (mode_i ? (!rd_ns_i || !wr_ns_i) : !ds_ns_i);
  assign rd_dir  = mode_i ? !rd_ns_i : rw_s_i;
  assign start_o = active && !active_q;
  assign stop    = !active && active_q;
  // mode 0 takes write data at access start, mode 1 at write strobe release
  assign wr_cap_o = (start_o && !rd_dir && !mode_i) || (stop && wr_pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_go_q   <= 1'b0;
      rd_go_q   <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      active_q <= active;
      if (start_o)   wr_pend_q <= mode_i && !rd_dir;
      else if (stop) wr_pend_q <= 1'b0;
      wr_go_q <= wr_cap_o;
      rd_go_q <= start_o && rd_dir;
      if (!active)      oe_q <= 1'b0;
      else if (rd_go_q) oe_q <= 1'b1;
    end
  end

  assign wr_go_o = wr_go_q;
  assign rd_go_o = rd_go_q;
  assign oe_o    = oe_q;

  a_r8_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_go_q && rd_go_q));
  a_r8_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_q |=> !wr_go_q);
  a_r8_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go_q |=> !rd_go_q);
  a_r9_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !oe_q);
  a_r9_oe_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> active_q);
endmodule

// File: rtl/hbd_addr_decode.sv
module hbd_addr_decode
  import hbd_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CH_SEL_W = 3,
  parameter int REG_W    = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output tgt_e                tgt_o,
  output logic [CH_SEL_W-1:0] ch_o,
  output logic [REG_W-1:0]    reg_o
);
  localparam int MSB = ADDR_W - 1;

  logic [CH_SEL_W-1:0] sel;
  assign sel   = addr_i[MSB-1 -: CH_SEL_W];
  assign ch_o  = sel;
  assign reg_o = addr_i[REG_W-1:0];

  always_comb begin
    if (!addr_i[MSB])              tgt_o = TGT_CHAN;
    else if (sel == '0)            tgt_o = TGT_BCAST;
    else if (sel[0] && !sel[1])    tgt_o = TGT_GLOB;
    else                           tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/hbd_read_mux.sv
module hbd_read_mux
  import hbd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int N_CH     = 8,
  parameter int CH_SEL_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_go_i,
  input  tgt_e                   tgt_i,
  input  logic [CH_SEL_W-1:0]    ch_i,
  input  logic [N_CH*DATA_W-1:0] ch_rdata_i,
  input  logic [DATA_W-1:0]      glb_rdata_i,
  output logic [DATA_W-1:0]      rdata_o
);
  logic [DATA_W-1:0] words [N_CH];
  logic [DATA_W-1:0] sel_word, rdata_q;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_word
      assign words[c] = ch_rdata_i[c*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    case (tgt_i)
      TGT_CHAN: sel_word = words[ch_i];
      TGT_GLOB: sel_word = glb_rdata_i;
      default:  sel_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_go_i) rdata_q <= sel_word;

  assign rdata_o = rdata_q;

  a_r4_dead_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go_i && (tgt_i == TGT_BCAST || tgt_i == TGT_NONE)) |=> (rdata_q == '0));
endmodule

// File: rtl/host_bus_decoder.sv
module host_bus_decoder
  import hbd_pkg::*;
#(
  parameter int  DATA_W      = 16,
  parameter int  ADDR_W      = 12,
  parameter int  N_CH        = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int CH_SEL_W    = $clog2(N_CH),
  localparam int REG_W       = ADDR_W - 1 - CH_SEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic                   cs_ni,
  input  logic                   ds_ni,
  input  logic                   rw_i,
  input  logic                   rd_ni,
  input  logic                   wr_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rdata_oe_o,
  output logic [N_CH-1:0]        ch_we_o,
  output logic [N_CH-1:0]        ch_re_o,
  output logic [REG_W-1:0]       reg_addr_o,
  output logic [DATA_W-1:0]      reg_wdata_o,
  input  logic [N_CH*DATA_W-1:0] ch_rdata_i,
  output logic                   glb_we_o,
  output logic                   glb_re_o,
  input  logic [DATA_W-1:0]      glb_rdata_i,
  input  logic [N_CH-1:0]        ch_irq_i,
  output logic                   irq_no
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw, synced;
  logic start, wr_cap, wr_go, rd_go, oe;

  assign raw = {cs_ni, ds_ni, rw_i, rd_ni, wr_ni};

  hbd_sync #(
    .W      (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSYNC{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  hbd_strobe_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .cs_ns_i (synced[4]),
    .ds_ns_i (synced[3]),
    .rw_s_i  (synced[2]),
    .rd_ns_i (synced[1]),
    .wr_ns_i (synced[0]),
    .start_o (start),
    .wr_cap_o(wr_cap),
    .wr_go_o (wr_go),
    .rd_go_o (rd_go),
    .oe_o    (oe)
  );

  tgt_e                tgt_d, tgt_q;
  logic [CH_SEL_W-1:0] ch_d, ch_q;
  logic [REG_W-1:0]    reg_d, reg_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                irq_q;

  hbd_addr_decode #(
    .ADDR_W  (ADDR_W),
    .CH_SEL_W(CH_SEL_W),
    .REG_W   (REG_W)
  ) u_dec (
    .addr_i(addr_i),
    .tgt_o (tgt_d),
    .ch_o  (ch_d),
    .reg_o (reg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= TGT_NONE;
      ch_q    <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      irq_q   <= 1'b1;
    end else begin
      if (start) begin
        tgt_q <= tgt_d;
        ch_q  <= ch_d;
        reg_q <= reg_d;
      end
      if (wr_cap) wdata_q <= wdata_i;
      irq_q <= ~|ch_irq_i;
    end
  end

  logic bcast;
  assign bcast = (tgt_q == TGT_BCAST);

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit        = (tgt_q == TGT_CHAN) && (ch_q == CH_SEL_W'(c));
      assign ch_we_o[c] = wr_go && (hit || bcast);
      assign ch_re_o[c] = rd_go && hit;
    end
  endgenerate

  assign glb_we_o    = wr_go && (tgt_q == TGT_GLOB);
  assign glb_re_o    = rd_go && (tgt_q == TGT_GLOB);
  assign reg_addr_o  = reg_q;
  assign reg_wdata_o = wdata_q;
  assign rdata_oe_o  = oe;
  assign irq_no      = irq_q;

  hbd_read_mux #(
    .DATA_W  (DATA_W),
    .N_CH    (N_CH),
    .CH_SEL_W(CH_SEL_W)
  ) u_rmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_go_i    (rd_go),
    .tgt_i      (tgt_q),
    .ch_i       (ch_q),
    .ch_rdata_i (ch_rdata_i),
    .glb_rdata_i(glb_rdata_i),
    .rdata_o    (rdata_o)
  );

  a_r2_we_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we_o) || (&ch_we_o));
  a_r1_re_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_re_o));
  a_r3_glb_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_we_o || glb_re_o) |-> (ch_we_o == '0 && ch_re_o == '0));
  a_r8_no_mixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|ch_we_o || glb_we_o) && (|ch_re_o || glb_re_o)));
  a_r10_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_irq_i) |=> !irq_no);
  a_r10_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ch_irq_i) |=> irq_no);
endmodule

// File: tb/host_bus_decoder_tb.sv
module host_bus_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        mode = 1'b0, cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        oe;
  logic [7:0]  ch_we, ch_re, reg_addr, ch_irq = '0;
  logic [15:0] reg_wdata, glb_rdata;
  logic [127:0] ch_rdata;
  logic        glb_we, glb_re, irq_n;

  host_bus_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .cs_ni(cs_n), .ds_ni(ds_n), .rw_i(rw), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(oe),
    .ch_we_o(ch_we), .ch_re_o(ch_re), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .ch_rdata_i(ch_rdata), .glb_we_o(glb_we), .glb_re_o(glb_re),
    .glb_rdata_i(glb_rdata), .ch_irq_i(ch_irq), .irq_no(irq_n)
  );

  // behavioural register files
  logic [15:0] ch_mem [8][256];
  logic [15:0] glb_mem [256];
  int we_ev = 0, re_ev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 256; r++) ch_mem[c][r] = '0;
      for (int r = 0; r < 256; r++) glb_mem[r] = '0;
    end else begin
      for (int c = 0; c < 8; c++)
        if (ch_we[c]) ch_mem[c][reg_addr] = reg_wdata;
      if (glb_we) glb_mem[reg_addr] = reg_wdata;
      if (|ch_we || glb_we) we_ev++;
      if (|ch_re || glb_re) re_ev++;
    end
  end

  always_comb begin
    for (int c = 0; c < 8; c++) ch_rdata[c*16 +: 16] = ch_mem[c][reg_addr];
    glb_rdata = glb_mem[reg_addr];
  end

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle();
    cs_n = 1; ds_n = 1; rd_n = 1; wr_n = 1; rw = 1;
  endtask

  task automatic do_write(input bit m, input logic [11:0] a, input logic [15:0] d0, input logic [15:0] d1);
    @(negedge clk);
    mode = m; addr = a; wdata = d0; cs_n = 0;
    if (m) wr_n = 0; else begin rw = 0; ds_n = 0; end
    repeat (6) @(negedge clk);
    wdata = d1;
    repeat (2) @(negedge clk);
    idle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input bit m, input logic [11:0] a, output logic [15:0] d,
                         output logic oe_mid, output logic oe_end);
    @(negedge clk);
    mode = m; addr = a; cs_n = 0;
    if (m) rd_n = 0; else begin rw = 1; ds_n = 0; end
    repeat (6) @(negedge clk);
    d = rdata; oe_mid = oe;
    idle();
    repeat (3) @(negedge clk);
    oe_end = oe;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] expval(input bit m, input int c, input int r);
    return 16'h5000 | (16'(m) << 11) | (16'(c) << 8) | 16'(r);
  endfunction

  // write in mode m, expected value arrives at the sampling point of that mode
  task automatic wr_sample(input bit m, input logic [11:0] a, input logic [15:0] v);
    if (m) do_write(1'b1, a, 16'h1234, v);
    else   do_write(1'b0, a, v, 16'h4321);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic om, oe2;
    int w0, r0;
    int regs[3] = '{0, 8'h3C, 8'hFF};

    repeat (3) @(negedge clk);
    // R11 reset state
    check(oe == 0 && ch_we == 0 && ch_re == 0 && !glb_we && !glb_re, "R11 pulses/oe", {ch_we, ch_re, 7'd0, oe}, 0);
    check(irq_n == 1, "R11 irq", irq_n, 1);
    check(rdata == 0, "R11 rdata", rdata, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1/R6/R7 sweep: write in one mode, read back in the other
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 3; i++) begin
          w0 = we_ev;
          wr_sample(m[0], 12'((c << 8) | regs[i]), expval(m[0], c, regs[i]));
          check(we_ev == w0 + 1, "R8 write pulse count", we_ev - w0, 1);
        end
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 3; i++) begin
          r0 = re_ev;
          do_read(!m[0], 12'((c << 8) | regs[i]), d, om, oe2);
          check(d == expval(m[0], c, regs[i]), m ? "R7 R1 readback" : "R6 R1 readback", d, expval(m[0], c, regs[i]));
          check(re_ev == r0 + 1, "R8 read pulse count", re_ev - r0, 1);
          check(om == 1, "R9 oe during read", om, 1);
          check(oe2 == 0, "R9 oe after release", oe2, 0);
        end
    end

    // R2 broadcast write
    w0 = we_ev;
    wr_sample(1'b1, 12'h810, 16'hBEEF);
    check(we_ev == w0 + 1, "R8 R2 broadcast single event", we_ev - w0, 1);
    for (int c = 0; c < 8; c++) begin
      do_read(c[0], 12'((c << 8) | 8'h10), d, om, oe2);
      check(d == 16'hBEEF, "R2 broadcast data", d, 16'hBEEF);
    end

    // R3 global region, bit 10 ignored
    wr_sample(1'b0, 12'h921, 16'hC0DE);
    wr_sample(1'b1, 12'hD22, 16'hF00D);
    do_read(1'b1, 12'hD21, d, om, oe2);
    check(d == 16'hC0DE, "R3 global a10 high", d, 16'hC0DE);
    do_read(1'b0, 12'h922, d, om, oe2);
    check(d == 16'hF00D, "R3 global a10 low", d, 16'hF00D);
    do_read(1'b0, 12'h121, d, om, oe2);
    check(d == 16'h0000, "R3 channel untouched", d, 0);

    // R4 upper region sweep: reads of bcast/undecoded give zero and no pulse
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 5) continue;
      r0 = re_ev;
      do_read(s[0], 12'h800 | 12'(s << 8) | 12'h03C, d, om, oe2);
      check(d == 16'h0000, "R4 dead read data", d, 0);
      check(re_ev == r0, "R4 dead read pulse", re_ev - r0, 0);
    end
    for (int s = 2; s < 8; s++) begin
      if (s == 5) continue;
      w0 = we_ev;
      wr_sample(s[0], 12'h800 | 12'(s << 8) | 12'h03C, 16'hDEAD);
      check(we_ev == w0, "R4 dead write pulse", we_ev - w0, 0);
      do_read(1'b0, 12'(s << 8) | 12'h03C, d, om, oe2);
      check(d == expval(1'b1, s, 8'h3C), "R4 dead write no effect", d, expval(1'b1, s, 8'h3C));
    end

    // R5 chip select high
    w0 = we_ev; r0 = re_ev;
    @(negedge clk);
    mode = 0; addr = 12'h010; wdata = 16'hBAD0; rw = 0; ds_n = 0;
    repeat (8) @(negedge clk);
    check(oe == 0, "R5 oe with cs high (write)", oe, 0);
    idle(); rw = 1; ds_n = 0;
    repeat (8) @(negedge clk);
    check(oe == 0, "R5 oe with cs high (read)", oe, 0);
    idle();
    repeat (6) @(negedge clk);
    check(we_ev == w0 && re_ev == r0, "R5 no pulses", we_ev - w0 + re_ev - r0, 0);
    do_read(1'b1, 12'h010, d, om, oe2);
    check(d == 16'hBEEF, "R5 register unchanged", d, 16'hBEEF);

    // R10 walking interrupt
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); ch_irq = 8'(1 << b);
      @(negedge clk);
      check(irq_n == 0, "R10 irq assert", irq_n, 0);
      ch_irq = '0;
      @(negedge clk);
      check(irq_n == 1, "R10 irq release", irq_n, 1);
    end

    finish_run();
  end
endmodule